// File: doc/BRIEF.md
# Memory Bandwidth and Integrity Tester

This block drives the user side of a wide memory controller so that a run measures sustained throughput and checks what comes back. After a start pulse it writes a generated pattern into a contiguous run of word addresses and times that write phase. Only when every write has been accepted does it request the same addresses again, time that read phase, and compare each returned word against the pattern regenerated from its address. Nothing is stored between the two phases.

The memory side is a single command channel with a valid/ready handshake, where write data travels with the command, plus a read-return channel with no back-pressure. Read data may come back with any latency but must arrive in request order. The block reports a write timer, a read timer, the number of beats moved in each direction and a saturating mismatch count. Those results stay valid and stable until the next start. Dividing beats by cycles and multiplying by the word width gives the bandwidth of each phase. At the default 512-bit width, 65536 beats move 4 MB.

Top module: `mem_bw_tester`

## Requirements
- R1: After reset, busy, done and cmd_valid are low and all five result outputs are zero.
- R2: A start pulse sampled while the block is not busy captures num_beats and base_addr, clears every result and drops done. busy is high from the next cycle. A start pulse while busy has no effect on the run or on its results.
- R3: In the write phase the block presents one write command (cmd_write high) per beat, at addresses base_addr+0 up to base_addr+N-1 in ascending order. A command that is not accepted stays valid with the same address and type until cmd_ready is high.
- R4: The data word for address a has 32-bit lanes. Lane k, at bits 32k+31 down to 32k, is formed from the seed s = a XOR (k * 0x9E3779B9 mod 2^32). The lane value is s shifted right by one, XORed with 0x80200003 when bit 0 of s is 1.
- R5: No read command (cmd_valid high with cmd_write low) is presented before all N writes have been accepted. Reads then cover the same N addresses in ascending order.
- R6: wr_cycles equals the number of clock cycles from the cycle of the first accepted write through the cycle of the last accepted write, inclusive. Cycles stalled by cmd_ready count.
- R7: rd_cycles equals the number of clock cycles from the first cycle a read command is presented through the cycle the last read word returns, inclusive.
- R8: At the end of a run, wr_beats and rd_beats both equal N, including N = 1. Neither ever exceeds the captured N.
- R9: Each returned word is compared, in arrival order, with the pattern for the next expected address, and err_count rises by one per differing word. rd_valid outside the read phase is ignored.
- R10: err_count saturates at all ones and does not wrap.
- R11: done rises in the cycle after the last read word returns, and busy falls with it. done and all results then hold stable until the next start.
- R12: A start with num_beats equal to zero issues no command. done is high and busy low in the next cycle, with all results zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock of the memory interface |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, sampled when not busy |
| num_beats | input | BEAT_W | Words to write and read back |
| base_addr | input | ADDR_W | First word address of the region |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Results of the last run are final |
| cmd_valid | output | 1 | Command presented to the memory |
| cmd_ready | input | 1 | Memory accepts the command this cycle |
| cmd_write | output | 1 | 1 = write command, 0 = read command |
| cmd_addr | output | ADDR_W | Word address of the command |
| cmd_wdata | output | DATA_W | Pattern word sent with a write |
| rd_valid | input | 1 | A read word is returned this cycle |
| rd_data | input | DATA_W | Returned read word |
| wr_cycles | output | TIMER_W | Write-phase timer |
| rd_cycles | output | TIMER_W | Read-phase timer |
| wr_beats | output | BEAT_W | Accepted write beats |
| rd_beats | output | BEAT_W | Returned read beats |
| err_count | output | ERR_W | Saturating mismatch count |

## Verification
Several properties are checked in every cycle. A stalled command keeps its address and type. No read is presented while writes are outstanding. Neither beat count passes the captured run length. The saturated error count stays at its ceiling. done excludes busy, and the results stay frozen while done is held. Other behaviour needs the bench's scenarios: the exact timer values under random stalls and read latency, the pattern content of every write, the one-cycle timing of done, how many corrupted words are counted, and the absence of any effect from a stray start pulse or a stray rd_valid.

// File: rtl/mem_bw_pkg.sv
package mem_bw_pkg;

  localparam int LANE_W = 32;
  localparam logic [LANE_W-1:0] LANE_POLY = 32'h8020_0003;
  localparam logic [LANE_W-1:0] LANE_MIX  = 32'h9E37_79B9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DRAIN,
    ST_DONE
  } tst_state_e;

  // per-lane seed: address folded with a lane-dependent constant
  function automatic logic [LANE_W-1:0] lane_seed(input logic [LANE_W-1:0] addr,
                                                  input int unsigned lane);
    logic [LANE_W-1:0] mix;
    mix = LANE_W'(lane) * LANE_MIX;
    return addr ^ mix;
  endfunction

  // one Galois right-shift step of the lane register
  function automatic logic [LANE_W-1:0] lane_step(input logic [LANE_W-1:0] s);
    logic [LANE_W-1:0] sh;
    sh = {1'b0, s[LANE_W-1:1]};
    return s[0] ? (sh ^ LANE_POLY) : sh;
  endfunction

endpackage

// File: rtl/mem_bw_pattern.sv
module mem_bw_pattern
  import mem_bw_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANE_W-1:0] addr_lane;
  assign addr_lane = LANE_W'(addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word[g*LANE_W +: LANE_W] = lane_step(lane_seed(addr_lane, g));
  end
endmodule

// File: rtl/mem_bw_counter.sv
module mem_bw_counter #(
  parameter int W        = 32,
  parameter bit SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  if (SATURATE) begin : g_sat
    always_ff @(posedge clk) begin
      if (!rst_n)                q <= '0;
      else if (clr)              q <= '0;
      else if (inc && q != TOP)  q <= q + W'(1);
    end
  end else begin : g_wrap
    always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else if (inc)  q <= q + W'(1);
    end
  end
endmodule

// File: rtl/mem_bw_ctrl.sv
module mem_bw_ctrl
  import mem_bw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] num_beats,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              cmd_ready,
  input  logic              rd_last,
  output tst_state_e        state,
  output logic              busy,
  output logic              done,
  output logic [BEAT_W-1:0] len_q,
  output logic [ADDR_W-1:0] base_q,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              start_ok,
  output logic              wr_accept,
  output logic              rd_accept
);
  tst_state_e        state_q;
  logic              done_q;
  logic [BEAT_W-1:0] idx_q;
  logic              issue_last;

  assign state      = state_q;
  assign done       = done_q;
  assign busy       = (state_q == ST_WRITE) || (state_q == ST_READ) || (state_q == ST_DRAIN);
  assign start_ok   = start && !busy;
  assign cmd_valid  = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign cmd_write  = (state_q == ST_WRITE);
  assign cmd_addr   = base_q + ADDR_W'(idx_q);
  assign wr_accept  = cmd_valid && cmd_write && cmd_ready;
  assign rd_accept  = cmd_valid && !cmd_write && cmd_ready;
  assign issue_last = (idx_q == len_q - BEAT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      idx_q   <= '0;
      len_q   <= '0;
      base_q  <= '0;
    end else if (start_ok) begin
      len_q  <= num_beats;
      base_q <= base_addr;
      idx_q  <= '0;
      if (num_beats == '0) begin
        state_q <= ST_DONE;
        done_q  <= 1'b1;
      end else begin
        state_q <= ST_WRITE;
        done_q  <= 1'b0;
      end
    end else begin
      case (state_q)
        ST_WRITE: begin
          if (wr_accept) begin
            if (issue_last) begin
              state_q <= ST_READ;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + BEAT_W'(1);
            end
          end
        end
        ST_READ: begin
          if (rd_accept) begin
            if (issue_last) state_q <= ST_DRAIN;
            else            idx_q   <= idx_q + BEAT_W'(1);
          end
        end
        ST_DRAIN: begin
          if (rd_last) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mem_bw_cmp.sv
module mem_bw_cmp #(
  parameter int DATA_W = 512,
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_read,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [BEAT_W-1:0] len_q,
  output logic              rd_fire,
  output logic              rd_last,
  output logic              mismatch
);
  logic [BEAT_W-1:0] exp_idx;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] exp_word;

  assign exp_addr = base_q + ADDR_W'(exp_idx);

  mem_bw_pattern #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_exp_pat (
    .addr (exp_addr),
    .word (exp_word)
  );

  assign rd_fire  = rd_valid && in_read;
  assign mismatch = rd_fire && (rd_data != exp_word);
  assign rd_last  = rd_fire && (exp_idx == len_q - BEAT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       exp_idx <= '0;
    else if (clr)     exp_idx <= '0;
    else if (rd_fire) exp_idx <= exp_idx + BEAT_W'(1);
  end
endmodule

// File: rtl/mem_bw_tester.sv
module mem_bw_tester
  import mem_bw_pkg::*;
#(
  parameter int DATA_W  = 512,
  parameter int ADDR_W  = 32,
  parameter int BEAT_W  = 32,
  parameter int TIMER_W = 32,
  parameter int ERR_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BEAT_W-1:0]  num_beats,
  input  logic [ADDR_W-1:0]  base_addr,
  output logic               busy,
  output logic               done,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic               cmd_write,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [DATA_W-1:0]  cmd_wdata,
  input  logic               rd_valid,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [TIMER_W-1:0] wr_cycles,
  output logic [TIMER_W-1:0] rd_cycles,
  output logic [BEAT_W-1:0]  wr_beats,
  output logic [BEAT_W-1:0]  rd_beats,
  output logic [ERR_W-1:0]   err_count
);
  // named internal events
  tst_state_e        state;
  logic [BEAT_W-1:0] len_q;
  logic [ADDR_W-1:0] base_q;
  logic              start_ok;
  logic              wr_accept;
  logic              rd_accept;
  logic              in_read;
  logic              rd_fire;
  logic              rd_last;
  logic              mismatch;
  logic              wr_time_en;

  mem_bw_ctrl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .num_beats (num_beats),
    .base_addr (base_addr),
    .cmd_ready (cmd_ready),
    .rd_last   (rd_last),
    .state     (state),
    .busy      (busy),
    .done      (done),
    .len_q     (len_q),
    .base_q    (base_q),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .start_ok  (start_ok),
    .wr_accept (wr_accept),
    .rd_accept (rd_accept)
  );

  mem_bw_pattern #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr_pat (
    .addr (cmd_addr),
    .word (cmd_wdata)
  );

  assign in_read    = (state == ST_READ) || (state == ST_DRAIN);
  assign wr_time_en = (state == ST_WRITE) && (wr_accept || wr_beats != '0);

  mem_bw_cmp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_ok),
    .in_read  (in_read),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .base_q   (base_q),
    .len_q    (len_q),
    .rd_fire  (rd_fire),
    .rd_last  (rd_last),
    .mismatch (mismatch)
  );

  mem_bw_counter #(.W(TIMER_W), .SATURATE(1'b0)) u_wr_timer (
    .clk (clk), .rst_n (rst_n), .clr (start_ok), .inc (wr_time_en), .q (wr_cycles)
  );

  mem_bw_counter #(.W(TIMER_W), .SATURATE(1'b0)) u_rd_timer (
    .clk (clk), .rst_n (rst_n), .clr (start_ok), .inc (in_read), .q (rd_cycles)
  );

  mem_bw_counter #(.W(BEAT_W), .SATURATE(1'b0)) u_wr_beats (
    .clk (clk), .rst_n (rst_n), .clr (start_ok), .inc (wr_accept), .q (wr_beats)
  );

  mem_bw_counter #(.W(BEAT_W), .SATURATE(1'b0)) u_rd_beats (
    .clk (clk), .rst_n (rst_n), .clr (start_ok), .inc (rd_fire), .q (rd_beats)
  );

  mem_bw_counter #(.W(ERR_W), .SATURATE(1'b1)) u_err (
    .clk (clk), .rst_n (rst_n), .clr (start_ok), .inc (mismatch), .q (err_count)
  );
endmodule

// File: rtl/mem_bw_tester_sva.sv
module mem_bw_tester_sva #(
  parameter int ADDR_W  = 32,
  parameter int BEAT_W  = 32,
  parameter int TIMER_W = 32,
  parameter int ERR_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               cmd_write,
  input logic [ADDR_W-1:0]  cmd_addr,
  input logic [TIMER_W-1:0] wr_cycles,
  input logic [TIMER_W-1:0] rd_cycles,
  input logic [BEAT_W-1:0]  wr_beats,
  input logic [BEAT_W-1:0]  rd_beats,
  input logic [ERR_W-1:0]   err_count,
  input logic [BEAT_W-1:0]  len_q
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_write)); // R3

  AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write |-> wr_beats == len_q); // R5

  AST_WR_BEATS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beats <= len_q); // R8

  AST_RD_BEATS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beats <= len_q); // R8

  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    err_count == ERR_MAX && !start |=> err_count == ERR_MAX); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(wr_cycles) && $stable(rd_cycles)
      && $stable(wr_beats) && $stable(rd_beats) && $stable(err_count)); // R11
endmodule

bind mem_bw_tester mem_bw_tester_sva #(
  .ADDR_W  (ADDR_W),
  .BEAT_W  (BEAT_W),
  .TIMER_W (TIMER_W),
  .ERR_W   (ERR_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_write (cmd_write),
  .cmd_addr  (cmd_addr),
  .wr_cycles (wr_cycles),
  .rd_cycles (rd_cycles),
  .wr_beats  (wr_beats),
  .rd_beats  (rd_beats),
  .err_count (err_count),
  .len_q     (len_q)
);

// File: tb/mem_bw_tester_test.sv
`timescale 1ns/1ps
module mem_bw_tester_test;
  localparam int DW = 512;
  localparam int AW = 32;
  localparam int BW = 32;
  localparam int TW = 32;
  localparam int EW = 4;
  localparam int EMAX = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [BW-1:0] num_beats = '0;
  logic [AW-1:0] base_addr = '0;
  logic          busy, done, cmd_valid, cmd_write;
  logic          cmd_ready = 1'b0;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic [TW-1:0] wr_cycles, rd_cycles;
  logic [BW-1:0] wr_beats, rd_beats;
  logic [EW-1:0] err_count;

  mem_bw_tester #(.DATA_W(DW), .ADDR_W(AW), .BEAT_W(BW), .TIMER_W(TW), .ERR_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_beats(num_beats), .base_addr(base_addr),
    .busy(busy), .done(done), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_cycles(wr_cycles), .rd_cycles(rd_cycles),
    .wr_beats(wr_beats), .rd_beats(rd_beats), .err_count(err_count)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench restatement of the pattern (R4)
  function automatic logic [DW-1:0] tb_pat(input logic [31:0] a);
    logic [DW-1:0] w;
    logic [31:0]   acc, s, t;
    acc = 32'd0;
    for (int k = 0; k < DW/32; k++) begin
      s = a ^ acc;
      t = s >> 1;
      if (s & 32'd1) t = t ^ 32'h8020_0003;
      w[k*32 +: 32] = t;
      acc = acc + 32'h9E37_79B9;
    end
    return w;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard state
  logic [AW-1:0] exp_wr[$];
  logic [AW-1:0] exp_rd[$];
  logic [DW-1:0] mem_model [int unsigned];
  typedef struct packed { logic [DW-1:0] d; int due; } ret_t;
  ret_t ret_q[$];
  int cur_n = 0, stall_pct = 0, corrupt_every = 0;
  int wr_cnt = 0, rd_issue = 0, rd_ret = 0;
  int k_w0 = -1, k_wl = -1, k_r0 = -1, k_rl = -1, k_done = -1;
  int wr_bad = 0, ord_bad = 0;
  bit armed = 0, spurious = 0;

  // memory model and monitor: acts at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_ready = 1'b0;
      rd_valid  = 1'b0;
    end else begin
      if (spurious) begin
        rd_valid = 1'b1;
        rd_data  = {16{32'hDEAD_BEEF}};
      end else if (ret_q.size() > 0 && ret_q[0].due <= cyc) begin
        ret_t r;
        r = ret_q.pop_front();
        rd_valid = 1'b1;
        rd_data  = r.d;
        rd_ret++;
        if (rd_ret == cur_n) k_rl = cyc;
      end else begin
        rd_valid = 1'b0;
      end
      cmd_ready = ($urandom_range(0, 99) >= stall_pct);
      if (cmd_valid && !cmd_write && k_r0 < 0) begin
        k_r0 = cyc;
        if (wr_cnt != cur_n) ord_bad++;
      end
      if (cmd_valid && cmd_ready) begin
        if (cmd_write) begin
          if (exp_wr.size() == 0 || exp_wr.pop_front() != cmd_addr) wr_bad++;
          if (cmd_wdata != tb_pat(cmd_addr)) wr_bad++;
          if (k_w0 < 0) k_w0 = cyc;
          k_wl = cyc;
          wr_cnt++;
          mem_model[cmd_addr] = cmd_wdata;
        end else begin
          ret_t r;
          if (exp_rd.size() == 0 || exp_rd.pop_front() != cmd_addr) ord_bad++;
          if (wr_cnt != cur_n) ord_bad++;
          r.d = mem_model.exists(cmd_addr) ? mem_model[cmd_addr] : '0;
          if (corrupt_every > 0 && (rd_issue % corrupt_every) == 0)
            r.d[rd_issue % DW] = ~r.d[rd_issue % DW];
          r.due = cyc + int'($urandom_range(1, 4));
          ret_q.push_back(r);
          rd_issue++;
        end
      end
      if (armed && done && k_done < 0) k_done = cyc;
    end
  end

  // driver: one complete run, expected items pushed into the scoreboard
  task automatic run(input logic [31:0] base, input int n, input int stall, input int ce,
                     input bit mid, input string tag);
    int exp_err, guard;
    bit pulsed;
    cur_n = n; stall_pct = stall; corrupt_every = ce;
    wr_cnt = 0; rd_issue = 0; rd_ret = 0; wr_bad = 0; ord_bad = 0;
    k_w0 = -1; k_wl = -1; k_r0 = -1; k_rl = -1; k_done = -1;
    exp_wr.delete(); exp_rd.delete(); mem_model.delete(); ret_q.delete();
    for (int i = 0; i < n; i++) begin
      exp_wr.push_back(base + 32'(i));
      exp_rd.push_back(base + 32'(i));
    end
    @(negedge clk);
    num_beats = BW'(n); base_addr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0; armed = 1'b1;
    chk("R2", {tag, " busy after start"}, busy, 1);
    chk("R2", {tag, " done cleared"}, done, 0);
    guard = 0; pulsed = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (mid && !pulsed && k_r0 >= 0) begin
        start = 1'b1; num_beats = 3; base_addr = 32'h7777; pulsed = 1;
      end else start = 1'b0;
    end
    start = 1'b0;
    @(negedge clk);
    chk("R11", {tag, " run finished"}, done, 1);
    exp_err = 0;
    if (ce > 0) exp_err = (n + ce - 1) / ce;
    if (exp_err > EMAX) exp_err = EMAX;
    chk("R3", {tag, " write address and data"}, wr_bad, 0);
    chk("R5", {tag, " read ordering"}, ord_bad + exp_rd.size(), 0);
    chk("R8", {tag, " wr_beats"}, wr_beats, n);
    chk("R8", {tag, " rd_beats"}, rd_beats, n);
    chk("R6", {tag, " wr_cycles"}, wr_cycles, k_wl - k_w0 + 1);
    chk("R7", {tag, " rd_cycles"}, rd_cycles, k_rl - k_r0 + 1);
    chk(ce > 0 ? "R10" : "R9", {tag, " err_count"}, err_count, exp_err);
    chk("R11", {tag, " done one cycle after last return"}, k_done, k_rl + 1);
    chk("R11", {tag, " busy low"}, busy, 0);
    armed = 1'b0;
  endtask

  task automatic hold_and_stray(input string tag);
    logic [TW-1:0] wc, rc;
    logic [BW-1:0] wb, rb;
    logic [EW-1:0] ec;
    wc = wr_cycles; rc = rd_cycles; wb = wr_beats; rb = rd_beats; ec = err_count;
    repeat (10) @(negedge clk);
    chk("R11", {tag, " wr_cycles hold"}, wr_cycles, wc);
    chk("R11", {tag, " rd_cycles hold"}, rd_cycles, rc);
    spurious = 1'b1;
    repeat (5) @(negedge clk);
    spurious = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", {tag, " stray rd_valid rd_beats"}, rd_beats, rb);
    chk("R9", {tag, " stray rd_valid err_count"}, err_count, ec);
    chk("R11", {tag, " wr_beats hold"}, wr_beats, wb);
    chk("R11", {tag, " done held"}, done, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "cmd_valid", cmd_valid, 0);
    chk("R1", "wr_cycles", wr_cycles, 0);
    chk("R1", "rd_cycles", rd_cycles, 0);
    chk("R1", "beats", wr_beats + rd_beats, 0);
    chk("R1", "err_count", err_count, 0);

    run(32'h0000_0100, 16, 0, 0, 0, "plain");
    hold_and_stray("plain");
    run(32'h0000_3000, 64, 40, 0, 0, "stalled");
    run(32'hFFFF_FFF0, 1, 30, 0, 0, "single");
    run(32'h0000_0500, 30, 20, 7, 0, "five_errors");
    run(32'h0000_0900, 40, 10, 2, 0, "saturate");
    run(32'h0000_1200, 24, 25, 0, 1, "start_while_busy");

    // R12 zero-length run
    @(negedge clk);
    num_beats = '0; base_addr = 32'h40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12", "zero run done", done, 1);
    chk("R12", "zero run busy", busy, 0);
    chk("R12", "zero run cmd_valid", cmd_valid, 0);
    chk("R12", "zero run results", wr_cycles + rd_cycles + wr_beats + rd_beats + err_count, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule